// File: doc/BRIEF.md
# NAND Page Single-Bit ECC Engine

This block computes a Hamming-style parity code over the bytes that move between a controller and a NAND flash page. It has two independent accumulators. One covers the main data area of the page. The other covers the spare area. Both see every byte on the inbound byte stream. Each accumulator folds the byte into its code only while its own lock is open. Software runs the sequence through a small control word. It clears an accumulator, opens its lock, moves the page or spare bytes, then closes the lock to freeze the result.

To check a page on read, software loads the code that was stored in the spare area into the compare register for that area. The engine XORs the stored code with the computed one and decodes the result at once. The status reports one of four outcomes: no error, a single-bit error it can correct, an error it cannot correct, or a fault in the stored code itself. For a correctable error it also gives the byte and bit location. No separate start command is needed.

The byte stream uses a valid/ready handshake, but the engine never applies back-pressure. `in_ready` is tied high, and a byte is taken on every cycle in which `in_valid` is high. The sender may therefore stream one byte per clock without pausing.

Top module: `nand_ecc1_engine`

## Requirements
- R1: After reset, both codes read all ones, both compare registers read all ones, both locks read 1, and both statuses read 00 with zero location outputs.
- R2: `in_ready` is always 1, and a byte is accepted on every clock in which `in_valid` is 1, giving one byte per clock.
- R3: While the main lock is 0, each accepted byte with an internal byte index a (0..511, advancing per accepted byte) XORs into `main_code`. The code is an inverted parity: it resets to all ones. For column k (0..2), data bit b toggles code bit 2k+1 if bit k of b is 1, and code bit 2k otherwise. For line j (0..8), the XOR of all eight data bits toggles code bit 7+2j if bit j of a is 1, and code bit 6+2j otherwise.
- R4: The spare accumulator uses the same scheme with its own 4-bit byte index and a 14-bit `spare_code`. It is gated only by the spare lock. Accumulation in either area leaves the other area's code unchanged.
- R5: While an area's lock is 1, its code does not change, whatever bytes flow.
- R6: A control write with bit 5 set (main) or bit 4 set (spare) sets that code to all ones and its byte index to 0 at the same clock edge. A byte accepted in the same cycle is dropped by that accumulator.
- R7: Control bit 7 is the main lock and bit 6 is the spare lock. Both are stored and read back on `main_lock` and `spare_lock` from the next cycle. A byte in the same cycle as the write still sees the old lock. Bits 5 and 4 are not stored, so a write with them at 0 clears nothing.
- R8: In the cycle after a compare write, the status reflects D = computed XOR stored. D equal to zero gives 00. Every true/complement pair of D differing gives 01. Exactly one set bit in D gives 11. Any other pattern gives 10.
- R9: When a status is 01, the error byte output equals the odd (complement) line bits of D, with line j as bit j. The error bit output equals the odd column bits, with column k as bit k. Both outputs are 0 for any other status.
- R10: The spare compare register and the spare status are independent of the main ones. Loading one leaves the other status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready, always 1 |
| in_data | input | 8 | Byte read from or written to the page |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word: [7] main lock, [6] spare lock, [5] main clear, [4] spare clear |
| main_lock | output | 1 | Current main lock |
| spare_lock | output | 1 | Current spare lock |
| cmp_main_wr | input | 1 | Load the main stored code |
| cmp_main_code | input | 24 | Stored main code |
| cmp_spare_wr | input | 1 | Load the spare stored code |
| cmp_spare_code | input | 14 | Stored spare code |
| main_code | output | 24 | Computed main code |
| spare_code | output | 14 | Computed spare code |
| main_status | output | 2 | Main error status |
| main_err_byte | output | 9 | Main error byte location |
| main_err_bit | output | 3 | Main error bit location |
| spare_status | output | 2 | Spare error status |
| spare_err_byte | output | 4 | Spare error byte location |
| spare_err_bit | output | 3 | Spare error bit location |

## Verification
A byte or a clear takes effect at the edge that samples it, so the code is due in the cycle after the last byte or the clear. A lock write is seen one cycle after the write. A status is due in the cycle after its compare write, because the decode is combinational from the compare register and the code. The bench drives every input at a falling edge and reads results at the next falling edge, so each check falls in the first cycle in which its result must hold. The sweep covers every byte and bit position in both areas, every single bit flipped in the stored code, and several double errors.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int COL_BITS = 6;

  typedef enum logic [1:0] {
    ECC_CLEAN    = 2'b00,
    ECC_FIXABLE  = 2'b01,
    ECC_MULTI    = 2'b10,
    ECC_CODE_BAD = 2'b11
  } ecc_stat_e;

  function automatic int code_width(int aw);
    return COL_BITS + 2 * aw;
  endfunction
endpackage

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc #(
  parameter int AW = 9,
  localparam int CW = nand_ecc_pkg::code_width(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          lock,
  input  logic          beat,
  input  logic [7:0]    data,
  output logic [CW-1:0] code
);
  logic [CW-1:0] code_q;
  logic [AW-1:0] idx_q;
  logic [CW-1:0] toggle;
  logic          byte_par;

  always_comb begin
    toggle   = '0;
    byte_par = ^data;
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 3; k++) begin
        if (b[k]) toggle[2*k+1] = toggle[2*k+1] ^ data[b];
        else      toggle[2*k]   = toggle[2*k]   ^ data[b];
      end
    end
    for (int j = 0; j < AW; j++) begin
      if (idx_q[j]) toggle[7+2*j] = byte_par;
      else          toggle[6+2*j] = byte_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '1;
      idx_q  <= '0;
    end else if (clear) begin
      code_q <= '1;
      idx_q  <= '0;
    end else if (beat && !lock) begin
      code_q <= code_q ^ toggle;
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign code = code_q;
endmodule

// File: rtl/nand_ecc_cmp.sv
module nand_ecc_cmp #(
  parameter int AW = 9,
  localparam int CW = nand_ecc_pkg::code_width(AW),
  localparam int NP = CW / 2
) (
  input  logic [CW-1:0] calc,
  input  logic [CW-1:0] stored,
  output logic [1:0]    status,
  output logic [AW-1:0] err_byte,
  output logic [2:0]    err_bit
);
  import nand_ecc_pkg::*;

  logic [CW-1:0] diff;
  logic [NP-1:0] pair_split;
  logic [NP-1:0] odd_bits;

  assign diff = calc ^ stored;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign pair_split[p] = diff[2*p] ^ diff[2*p+1];
    assign odd_bits[p]   = diff[2*p+1];
  end

  ecc_stat_e st;
  always_comb begin
    if (diff == '0)                 st = ECC_CLEAN;
    else if (&pair_split)           st = ECC_FIXABLE;
    else if ($countones(diff) == 1) st = ECC_CODE_BAD;
    else                            st = ECC_MULTI;
  end

  assign status   = st;
  assign err_bit  = (st == ECC_FIXABLE) ? odd_bits[2:0]    : '0;
  assign err_byte = (st == ECC_FIXABLE) ? odd_bits[NP-1:3] : '0;
endmodule

// File: rtl/nand_ecc1_engine.sv
module nand_ecc1_engine #(
  parameter int MAIN_AW  = 9,
  parameter int SPARE_AW = 4,
  localparam int MCW = nand_ecc_pkg::code_width(MAIN_AW),
  localparam int SCW = nand_ecc_pkg::code_width(SPARE_AW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_data,
  input  logic                ctl_wr,
  input  logic [7:0]          ctl_wdata,
  output logic                main_lock,
  output logic                spare_lock,
  input  logic                cmp_main_wr,
  input  logic [MCW-1:0]      cmp_main_code,
  input  logic                cmp_spare_wr,
  input  logic [SCW-1:0]      cmp_spare_code,
  output logic [MCW-1:0]      main_code,
  output logic [SCW-1:0]      spare_code,
  output logic [1:0]          main_status,
  output logic [MAIN_AW-1:0]  main_err_byte,
  output logic [2:0]          main_err_bit,
  output logic [1:0]          spare_status,
  output logic [SPARE_AW-1:0] spare_err_byte,
  output logic [2:0]          spare_err_bit
);
  logic lock_main_q, lock_spare_q;
  logic clr_main, clr_spare, beat;
  logic [MCW-1:0] cmp_main_q;
  logic [SCW-1:0] cmp_spare_q;
  logic unused_ctl;

  assign in_ready   = 1'b1;
  assign beat       = in_valid & in_ready;
  assign clr_main   = ctl_wr & ctl_wdata[5];
  assign clr_spare  = ctl_wr & ctl_wdata[4];
  assign unused_ctl = ^ctl_wdata[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_main_q  <= 1'b1;
      lock_spare_q <= 1'b1;
    end else if (ctl_wr) begin
      lock_main_q  <= ctl_wdata[7];
      lock_spare_q <= ctl_wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_main_q  <= '1;
      cmp_spare_q <= '1;
    end else begin
      if (cmp_main_wr)  cmp_main_q  <= cmp_main_code;
      if (cmp_spare_wr) cmp_spare_q <= cmp_spare_code;
    end
  end

  assign main_lock  = lock_main_q;
  assign spare_lock = lock_spare_q;

  nand_ecc_acc #(.AW(MAIN_AW)) u_acc_main (
    .clk(clk), .rst_n(rst_n), .clear(clr_main), .lock(lock_main_q),
    .beat(beat), .data(in_data), .code(main_code)
  );

  nand_ecc_acc #(.AW(SPARE_AW)) u_acc_spare (
    .clk(clk), .rst_n(rst_n), .clear(clr_spare), .lock(lock_spare_q),
    .beat(beat), .data(in_data), .code(spare_code)
  );

  nand_ecc_cmp #(.AW(MAIN_AW)) u_cmp_main (
    .calc(main_code), .stored(cmp_main_q), .status(main_status),
    .err_byte(main_err_byte), .err_bit(main_err_bit)
  );

  nand_ecc_cmp #(.AW(SPARE_AW)) u_cmp_spare (
    .calc(spare_code), .stored(cmp_spare_q), .status(spare_status),
    .err_byte(spare_err_byte), .err_bit(spare_err_bit)
  );
endmodule

// File: rtl/nand_ecc1_engine_chk.sv
module nand_ecc1_engine_chk #(
  parameter int MCW = 24,
  parameter int SCW = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           ctl_wr,
  input logic [7:0]     ctl_wdata,
  input logic           main_lock,
  input logic           spare_lock,
  input logic [MCW-1:0] main_code,
  input logic [SCW-1:0] spare_code,
  input logic [MCW-1:0] cmp_main_q,
  input logic [1:0]     main_status
);
  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  p_main_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_lock && !(ctl_wr && ctl_wdata[5])) |=> $stable(main_code));

  p_spare_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_lock && !(ctl_wr && ctl_wdata[4])) |=> $stable(spare_code));

  p_main_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[5]) |=> (main_code == '1));

  p_lock_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (main_lock == $past(ctl_wdata[7]) && spare_lock == $past(ctl_wdata[6])));

  p_clean_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (main_status == 2'b00) == (main_code == cmp_main_q));

  p_code_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (main_status == 2'b11) |-> ($countones(main_code ^ cmp_main_q) == 1));
endmodule

bind nand_ecc1_engine nand_ecc1_engine_chk #(.MCW(MCW), .SCW(SCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .ctl_wr(ctl_wr),
  .ctl_wdata(ctl_wdata), .main_lock(main_lock), .spare_lock(spare_lock),
  .main_code(main_code), .spare_code(spare_code), .cmp_main_q(cmp_main_q),
  .main_status(main_status)
);

// File: tb/nand_ecc1_engine_tb.sv
`timescale 1ns/1ps
module nand_ecc1_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        main_lock, spare_lock;
  logic        cmp_main_wr = 1'b0;
  logic [23:0] cmp_main_code = '0;
  logic        cmp_spare_wr = 1'b0;
  logic [13:0] cmp_spare_code = '0;
  logic [23:0] main_code;
  logic [13:0] spare_code;
  logic [1:0]  main_status, spare_status;
  logic [8:0]  main_err_byte;
  logic [2:0]  main_err_bit, spare_err_bit;
  logic [3:0]  spare_err_byte;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_main, exp_page;
  logic [13:0] exp_spare;

  always #5 clk = ~clk;

  nand_ecc1_engine u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .main_lock(main_lock), .spare_lock(spare_lock),
    .cmp_main_wr(cmp_main_wr), .cmp_main_code(cmp_main_code),
    .cmp_spare_wr(cmp_spare_wr), .cmp_spare_code(cmp_spare_code),
    .main_code(main_code), .spare_code(spare_code),
    .main_status(main_status), .main_err_byte(main_err_byte),
    .main_err_bit(main_err_bit), .spare_status(spare_status),
    .spare_err_byte(spare_err_byte), .spare_err_bit(spare_err_bit)
  );

  function automatic logic [23:0] sig(int a, int b, int aw);
    logic [23:0] r = '0;
    for (int k = 0; k < 3; k++) r[2*k + ((b >> k) & 1)] = 1'b1;
    for (int j = 0; j < aw; j++) r[6 + 2*j + ((a >> j) & 1)] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] pat(int i, int seed);
    return 8'((i * 37 + (i >> 2) + seed) & 255);
  endfunction

  function automatic logic [23:0] page_code(int n, int seed, int aw, int fa, int fb);
    logic [23:0] c = '1;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = pat(i, seed);
      if (i == fa) d[fb] = ~d[fb];
      for (int b = 0; b < 8; b++) if (d[b]) c = c ^ sig(i, b, aw);
    end
    return c;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic feed(int n, int seed, int fa, int fb);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = pat(i, seed);
      if (i == fa) d[fb] = ~d[fb];
      in_valid = 1'b1; in_data = d;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic ctl(logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic load_main(logic [23:0] v);
    cmp_main_wr = 1'b1; cmp_main_code = v;
    @(negedge clk);
    cmp_main_wr = 1'b0;
  endtask

  task automatic load_spare(logic [13:0] v);
    cmp_spare_wr = 1'b1; cmp_spare_code = v;
    @(negedge clk);
    cmp_spare_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 main_code", 32'(main_code), 32'hFFFFFF);
    chk("R1 spare_code", 32'(spare_code), 32'h3FFF);
    chk("R1 locks", {30'd0, main_lock, spare_lock}, 32'd3);
    chk("R1 status", {28'd0, main_status, spare_status}, 32'd0);
    chk("R1 location", {20'd0, main_err_byte, main_err_bit}, 32'd0);
    chk("R2 in_ready", 32'(in_ready), 32'd1);

    // R3 main page, one byte per clock, spare stays locked
    ctl(8'h70);
    chk("R7 lock readback", {30'd0, main_lock, spare_lock}, 32'd1);
    feed(512, 5, -1, 0);
    ctl(8'hC0);
    exp_page = page_code(512, 5, 9, -1, 0);
    exp_main = exp_page;
    chk("R3 main code", 32'(main_code), 32'(exp_main));
    chk("R4 spare untouched", 32'(spare_code), 32'h3FFF);
    chk("R2 in_ready streaming", 32'(in_ready), 32'd1);

    // R5 locked main ignores data
    feed(20, 77, -1, 0);
    chk("R5 main frozen", 32'(main_code), 32'(exp_main));

    // R4 spare area
    ctl(8'h90);
    feed(16, 9, -1, 0);
    ctl(8'hC0);
    exp_spare = page_code(16, 9, 4, -1, 0)[13:0];
    chk("R4 spare code", 32'(spare_code), 32'(exp_spare));
    chk("R4 main unchanged", 32'(main_code), 32'(exp_main));

    // R8 / R9 main compare sweep
    load_main(exp_main);
    chk("R8 clean", 32'(main_status), 32'd0);
    for (int a = 0; a < 512; a++) begin
      for (int b = 0; b < 8; b++) begin
        load_main(exp_main ^ sig(a, b, 9));
        chk("R8 fixable", 32'(main_status), 32'd1);
        chk("R9 location", {20'd0, main_err_byte, main_err_bit}, 32'((a << 3) | b));
      end
    end
    for (int i = 0; i < 24; i++) begin
      load_main(exp_main ^ (24'd1 << i));
      chk("R8 code fault", 32'(main_status), 32'd3);
      chk("R9 no location", {20'd0, main_err_byte, main_err_bit}, 32'd0);
    end
    load_main(exp_main ^ sig(0, 0, 9) ^ sig(0, 1, 9));
    chk("R8 double same byte", 32'(main_status), 32'd2);
    load_main(exp_main ^ sig(3, 2, 9) ^ sig(400, 7, 9));
    chk("R8 double spread", 32'(main_status), 32'd2);
    load_main(exp_main ^ 24'h000003);
    chk("R8 double code bits", 32'(main_status), 32'd2);
    load_main(exp_main);

    // R10 spare compare sweep, main status unaffected
    load_spare(exp_spare);
    chk("R10 spare clean", 32'(spare_status), 32'd0);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 8; b++) begin
        load_spare(exp_spare ^ sig(a, b, 4)[13:0]);
        chk("R10 spare fixable", 32'(spare_status), 32'd1);
        chk("R10 spare location", {25'd0, spare_err_byte, spare_err_bit}, 32'((a << 3) | b));
        chk("R10 main independent", 32'(main_status), 32'd0);
      end
    end
    load_spare(exp_spare ^ 14'h0100);
    chk("R10 spare code fault", 32'(spare_status), 32'd3);
    load_main(exp_main ^ sig(9, 4, 9));
    chk("R10 spare independent", 32'(spare_status), 32'd3);

    // R9 real data error against the clean code
    ctl(8'h60);
    feed(512, 5, 300, 6);
    ctl(8'hC0);
    load_main(exp_page);
    chk("R9 data error status", 32'(main_status), 32'd1);
    chk("R9 data error location", {20'd0, main_err_byte, main_err_bit}, 32'((300 << 3) | 6));

    // R6 clear beats a byte in the same cycle
    ctl_wr = 1'b1; ctl_wdata = 8'h60; in_valid = 1'b1; in_data = 8'h01;
    @(negedge clk);
    ctl_wr = 1'b0; in_valid = 1'b0;
    chk("R6 clear priority", 32'(main_code), 32'hFFFFFF);
    in_valid = 1'b1; in_data = 8'h01;
    @(negedge clk);
    in_valid = 1'b0;
    exp_main = 24'hFFFFFF ^ sig(0, 0, 9);
    chk("R6 index reset", 32'(main_code), 32'(exp_main));

    // R7 no clear without bit 5; lock seen next cycle
    ctl(8'h40);
    chk("R7 no clear", 32'(main_code), 32'(exp_main));
    ctl_wr = 1'b1; ctl_wdata = 8'hC0; in_valid = 1'b1; in_data = 8'h02;
    @(negedge clk);
    ctl_wr = 1'b0; in_valid = 1'b0;
    exp_main = exp_main ^ sig(1, 1, 9);
    chk("R7 old lock used", 32'(main_code), 32'(exp_main));
    chk("R7 lock set", 32'(main_lock), 32'd1);
    feed(1, 0, 0, 0);
    chk("R5 frozen after lock", 32'(main_code), 32'(exp_main));

    finish_run();
  end
endmodule